// File: doc/BRIEF.md
# Gatable Astable/Monostable Pulse Timer

This block is a clock-driven replacement for a resistor-capacitor multivibrator. Two counts on its inputs set the timing. `halfPeriod` is the number of clock cycles between toggles of the fast oscillator. `pulseLen` is the number of clock cycles a one-shot pulse lasts.

In free-running (astable) mode the block drives a square wave with equal high and low times on `q`, and the inverse of that wave on `qN`. A raw oscillator, `osc`, runs at twice the frequency of `q`. The oscillator can be gated by an active-high enable, by an active-low enable, or by both.

When neither enable is active, the block acts as a one-shot (monostable). A pulse of fixed length can be started in two ways: by a rising edge on `trigRise` while `trigFall` is low, or by a falling edge on `trigFall` while `trigRise` is high. A level on `retrig` keeps the pulse stretched for as long as it is held. The external clear `clearIn` ends any pulse at once and blocks new pulses while it is held. A low level on `rstN` clears all state.

Top module: `pulse_timer`

## Requirements
- R1: While `rstN` is low and after it is released, `q`=0, `qN`=1 and `osc`=0 until a pulse or the oscillator starts.
- R2: The oscillator runs when `runHi`=1 or `runLo`=0. When `runHi`=0 and `runLo`=1, `q` and `osc` fall to 0 within one clock and stay at 0.
- R3: In astable mode `q` is high for 2*`halfPeriod` cycles and low for 2*`halfPeriod` cycles.
- R4: In astable mode `osc` toggles every `halfPeriod` cycles, so its period is half that of `q`.
- R5: `qN` is always the exact inverse of `q`, including while `clearIn` is high.
- R6: A rising edge on `trigRise` while `trigFall` is low starts a pulse of `pulseLen` cycles. `q` goes high on the third rising clock edge after the input changes.
- R7: A falling edge on `trigFall` while `trigRise` is high starts a pulse of `pulseLen` cycles.
- R8: The pulse width does not depend on how long the trigger input stays asserted.
- R9: A trigger edge that arrives while a pulse is active is ignored. A rising edge on `trigRise` while `trigFall` is high starts nothing.
- R10: While the synchronized `retrig` is high, the pulse count is reloaded every cycle. `retrig` alone also starts a pulse. The pulse ends `pulseLen` cycles after the last cycle in which `retrig` is seen high.
- R11: A high level on `clearIn` forces `q` low in the same cycle, ends any pulse, and blocks triggers for as long as it is held.
- R12: Trigger and retrigger inputs are ignored while the oscillator is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low (power-on reset) |
| halfPeriod | input | CNT_W | Oscillator half period in clock cycles (must be 1 or more) |
| pulseLen | input | CNT_W | One-shot pulse length in clock cycles |
| runHi | input | 1 | Astable enable, active high |
| runLo | input | 1 | Astable enable, active low |
| trigRise | input | 1 | Trigger on rising edge |
| trigFall | input | 1 | Trigger on falling edge |
| retrig | input | 1 | Retrigger level; reloads the pulse while high |
| clearIn | input | 1 | External clear, active high |
| q | output | 1 | Main output |
| qN | output | 1 | Inverse of `q` |
| osc | output | 1 | Raw oscillator output |

## Verification
Three pairs of functions can fall in the same cycle. A trigger edge can meet a pulse that is already counting. A retrigger can land in the middle of a pulse that a trigger started. The external clear can cut a pulse that is in progress. Each pair is provoked by driving the second input a fixed number of cycles after the first. The bench computes the expected pulse width from the synchronizer latency and checks it in a scoreboard that measures every high run on `q`. A trigger fired while the oscillator runs is judged by stopping the oscillator and seeing `q` fall at once, rather than stay high for the remainder of a one-shot pulse.

// File: rtl/pt_pkg.sv
package pt_pkg;
  typedef struct packed {
    logic run;    // astable oscillator enabled
    logic load;   // reload the one-shot count
    logic clear;  // external clear active
  } tmrStrobe_t;
endpackage

// File: rtl/pt_ctrl.sv
module pt_ctrl
  import pt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       runHi,
  input  logic       runLo,
  input  logic       trigRise,
  input  logic       trigFall,
  input  logic       retrig,
  input  logic       clearIn,
  input  logic       monoBusy,
  output tmrStrobe_t stb
);
  localparam int NUM_IN = 3;
  localparam int IDX_RISE = 0;
  localparam int IDX_FALL = 1;
  localparam int IDX_RETRIG = 2;

  logic [NUM_IN-1:0] rawIn;
  logic [NUM_IN-1:0] syncA, syncB, syncPrev;

  assign rawIn = {retrig, trigFall, trigRise};

  // two-flop synchronizer plus one history flop per input
  for (genvar i = 0; i < NUM_IN; i++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncA[i]    <= 1'b0;
        syncB[i]    <= 1'b0;
        syncPrev[i] <= 1'b0;
      end else begin
        syncA[i]    <= rawIn[i];
        syncB[i]    <= syncA[i];
        syncPrev[i] <= syncB[i];
      end
    end
  end

  logic trigUp, trigDown, trigEdge, retrigHigh;

  assign trigUp     = syncB[IDX_RISE] & ~syncPrev[IDX_RISE] & ~syncB[IDX_FALL];
  assign trigDown   = ~syncB[IDX_FALL] & syncPrev[IDX_FALL] & syncB[IDX_RISE];
  assign trigEdge   = trigUp | trigDown;
  assign retrigHigh = syncB[IDX_RETRIG];

  always_comb begin
    stb.run   = runHi | ~runLo;
    stb.clear = clearIn;
    stb.load  = ~clearIn & ~stb.run & ((trigEdge & ~monoBusy) | retrigHigh);
  end

  // a synchronized edge lasts exactly one cycle
  assert_edge_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    trigEdge |=> !trigEdge);
endmodule

// File: rtl/pt_datapath.sv
module pt_datapath
  import pt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       stb,
  input  logic [CNT_W-1:0] halfPeriod,
  input  logic [CNT_W-1:0] pulseLen,
  output logic             monoBusy,
  output logic             qOut,
  output logic             oscOut
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] oscCnt;
  logic [CNT_W-1:0] monoCnt;
  logic             oscReg;
  logic             astQ;
  logic             halfTick;

  assign halfTick = (oscCnt + CNT_ONE) >= halfPeriod;

  // oscillator and divide-by-two square wave
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oscCnt <= '0;
      oscReg <= 1'b0;
      astQ   <= 1'b0;
    end else if (stb.clear || !stb.run) begin
      oscCnt <= '0;
      oscReg <= 1'b0;
      astQ   <= 1'b0;
    end else if (halfTick) begin
      oscCnt <= '0;
      oscReg <= ~oscReg;
      if (!oscReg) astQ <= ~astQ;
    end else begin
      oscCnt <= oscCnt + CNT_ONE;
    end
  end

  // one-shot down counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 monoCnt <= '0;
    else if (stb.clear)        monoCnt <= '0;
    else if (stb.load)         monoCnt <= pulseLen;
    else if (monoCnt != '0)    monoCnt <= monoCnt - CNT_ONE;
  end

  assign monoBusy = monoCnt != '0;
  assign qOut     = (astQ | monoBusy) & ~stb.clear;
  assign oscOut   = oscReg;

  assert_clear_flush_R11: assert property (@(posedge clk) disable iff (!rstN)
    stb.clear |=> (monoCnt == '0 && !astQ && !oscReg));
  assert_stop_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !stb.run |=> (!oscReg && !astQ));
  assert_q_on_osc_rise_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(astQ) |-> $rose(oscReg));
  assert_osc_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.run && halfPeriod != '0) |-> (oscCnt < halfPeriod));
endmodule

// File: rtl/pulse_timer.sv
module pulse_timer
  import pt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] halfPeriod,
  input  logic [CNT_W-1:0] pulseLen,
  input  logic             runHi,
  input  logic             runLo,
  input  logic             trigRise,
  input  logic             trigFall,
  input  logic             retrig,
  input  logic             clearIn,
  output logic             q,
  output logic             qN,
  output logic             osc
);
  tmrStrobe_t stb;
  logic       monoBusy;
  logic       qOut;

  pt_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .runHi(runHi), .runLo(runLo),
    .trigRise(trigRise), .trigFall(trigFall), .retrig(retrig),
    .clearIn(clearIn), .monoBusy(monoBusy), .stb(stb)
  );

  pt_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .halfPeriod(halfPeriod),
    .pulseLen(pulseLen), .monoBusy(monoBusy), .qOut(qOut), .oscOut(osc)
  );

  assign q  = qOut;
  assign qN = ~qOut;
endmodule

// File: tb/pulse_timer_tb.sv
module pulse_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;
  localparam int HALF = 3;
  localparam int PLEN = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [CNT_W-1:0] halfPeriod = CNT_W'(HALF);
  logic [CNT_W-1:0] pulseLen = CNT_W'(PLEN);
  logic runHi = 1'b0, runLo = 1'b1;
  logic trigRise = 1'b0, trigFall = 1'b0, retrig = 1'b0, clearIn = 1'b0;
  logic q, qN, osc;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit monoWatch = 1'b0;
  int expQ[$];
  int width = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_timer #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .halfPeriod(halfPeriod), .pulseLen(pulseLen),
    .runHi(runHi), .runLo(runLo), .trigRise(trigRise), .trigFall(trigFall),
    .retrig(retrig), .clearIn(clearIn), .q(q), .qN(qN), .osc(osc)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // scoreboard monitor: measures each high run of q in one-shot mode
  always @(posedge clk) begin
    #1;
    if (rstN) check(qN === ~q, "R5 qN inverse", qN, ~q);
    if (monoWatch) begin
      if (q) width++;
      else if (width > 0) begin
        if (expQ.size() == 0) check(1'b0, "R9 unexpected pulse", width, 0);
        else begin
          int e;
          e = expQ.pop_front();
          check(width == e, "R6-R11 pulse width", width, e);
        end
        width = 0;
      end
    end
  end

  task automatic measureAstable(input string tag);
    int qHigh = 0, qTr = 0, oTr = 0;
    logic pq, po;
    cyc(4 * HALF);
    pq = q; po = osc;
    for (int i = 0; i < 8 * HALF; i++) begin
      @(negedge clk);
      if (q) qHigh++;
      if (q != pq) qTr++;
      if (osc != po) oTr++;
      pq = q; po = osc;
    end
    check(qHigh == 4 * HALF, {tag, " R3 q duty"}, qHigh, 4 * HALF);
    check(qTr == 4, {tag, " R3 q transitions"}, qTr, 4);
    check(oTr == 8, {tag, " R4 osc transitions"}, oTr, 8);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    cyc(3);
    check(q == 1'b0 && qN == 1'b1 && osc == 1'b0, "R1 reset state", {q, qN, osc}, 3'b010);
    rstN = 1'b1;
    cyc(3);
    check(q == 1'b0 && osc == 1'b0, "R1 after reset", {q, osc}, 0);
    monoWatch = 1'b1;

    // R6 rising trigger with latency check
    trigRise = 1'b1; expQ.push_back(PLEN);
    cyc(2);
    check(q == 1'b0, "R6 latency low", q, 0);
    cyc(1);
    check(q == 1'b1, "R6 latency high", q, 1);
    trigRise = 1'b0;
    cyc(20);

    // R8 long trigger
    trigRise = 1'b1; expQ.push_back(PLEN);
    cyc(30);
    trigRise = 1'b0;
    cyc(5);

    // R9 rise while trigFall high: nothing; R7 falling edge fires
    trigFall = 1'b1;
    cyc(4);
    trigRise = 1'b1;
    cyc(8);
    check(q == 1'b0, "R9 rise blocked by trigFall", q, 0);
    trigFall = 1'b0; expQ.push_back(PLEN);
    cyc(20);
    trigRise = 1'b0;
    cyc(5);

    // R9 edge during active pulse ignored
    trigRise = 1'b1; expQ.push_back(PLEN);
    cyc(2); trigRise = 1'b0;
    cyc(2); trigRise = 1'b1;
    cyc(2); trigRise = 1'b0;
    cyc(20);

    // R10 retrig alone for 4 cycles
    retrig = 1'b1; expQ.push_back(4 + PLEN - 1);
    cyc(4); retrig = 1'b0;
    cyc(25);

    // R10 retrig 3 cycles after trigger, held 3 cycles
    trigRise = 1'b1; expQ.push_back(3 + 3 + PLEN - 1);
    cyc(3); trigRise = 1'b0; retrig = 1'b1;
    cyc(3); retrig = 1'b0;
    cyc(25);

    // R11 clear cuts a pulse 6 cycles after trigger
    trigRise = 1'b1; expQ.push_back(4);
    cyc(2); trigRise = 1'b0;
    cyc(4);
    check(q == 1'b1, "R11 pulse before clear", q, 1);
    clearIn = 1'b1;
    #1;
    check(q == 1'b0 && qN == 1'b1, "R11 R5 immediate clear", {q, qN}, 2'b01);
    cyc(3); clearIn = 1'b0;
    cyc(15);

    // R11 triggers blocked while clear held
    clearIn = 1'b1; trigRise = 1'b1;
    cyc(8);
    check(q == 1'b0, "R11 trigger blocked", q, 0);
    clearIn = 1'b0;
    cyc(20);
    trigRise = 1'b0;
    cyc(5);
    check(expQ.size() == 0, "R6 all pulses seen", expQ.size(), 0);
    monoWatch = 1'b0;

    // astable with active-high enable
    runHi = 1'b1;
    measureAstable("runHi");
    // R12 trigger while running is ignored
    trigRise = 1'b1;
    cyc(4); trigRise = 1'b0;
    runHi = 1'b0;
    cyc(2);
    check(q == 1'b0, "R12 trigger ignored in astable", q, 0);
    cyc(10);
    check(q == 1'b0 && osc == 1'b0, "R2 stopped", {q, osc}, 0);

    // astable with active-low enable
    runLo = 1'b0;
    measureAstable("runLo");
    runLo = 1'b1;
    cyc(2);
    check(q == 1'b0 && osc == 1'b0, "R2 stopped again", {q, osc}, 0);

    done = 1'b1;
    report();
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      report();
    end
  end
endmodule